// File: doc/BRIEF.md
# Reset and Clock-Quality Sequencer

This block decides when the core of a small microcontroller may leave reset, and which clock it then runs on. It combines three reset sources: an asynchronous power-on reset, a synchronous low-voltage detector level, and an external reset pin. The pin is synchronized and must be held for a minimum number of cycles before it counts. The oscillator cannot be observed directly, so the block receives a digital signal that toggles while the oscillator runs. It samples that signal through a synchronizer and counts its edges.

Power-on and low-voltage resets start a clock quality check. The check passes once a programmable number of oscillator edges has arrived with no gap longer than a set window. If the check has not passed when its timeout runs out, the block selects the internal self clock instead. An external reset skips the check when the oscillator is still active, and also when the self clock is already selected. Both outcomes of the check, and both skip paths, lead into a fixed reset stretch before the core is released.

Reset causes are kept as sticky flags that software clears by writing one to a bit. A set power-on flag tells software that memory contents cannot be trusted.

Top module: `rst_clk_seq`

## Requirements
- R1: The external pin starts a reset only after its synchronized level has been high for more than EXT_MIN_CYCLES (2) consecutive cycles. A pulse of 2 cycles leaves `coreRstOut` low and the flags unchanged. A pulse of 3 cycles starts a reset.
- R2: Every release goes through a stretch phase in which `coreRstOut` stays high for exactly STRETCH_CYCLES (192) cycles. For an external reset that skips the check, the release comes 192 to 198 cycles after the pin falls.
- R3: While `porIn` is high, `coreRstOut` is 1, `clkSelOscOut` is 0 and `flagsOut` is 3'b001. When `porIn` is released, a clock quality check starts.
- R4: The check passes after GOOD_EDGES (16) synchronized oscillator edges, each no more than GAP_WINDOW (8) cycles after the previous one. A pass sets `clkSelOscOut` to 1 and enters the stretch. A gap of GAP_WINDOW cycles or more restarts the edge count.
- R5: If the check has not passed after CQ_TIMEOUT (1000) cycles, `clkSelOscOut` goes to 0 (self clock) and the stretch follows.
- R6: An external reset while the oscillator is active and selected skips the check. `clkSelOscOut` stays 1.
- R7: An external reset while the oscillator is selected but has shown no edge for GAP_WINDOW cycles runs the check.
- R8: `flagsOut` bit 0 marks power-on reset, bit 1 low-voltage reset and bit 2 external reset. Each bit is sticky and is cleared by a one on the matching bit of `flagClrIn` for one cycle. A set that occurs in the same cycle as a clear wins.
- R9: While `lvrIn` is high, `coreRstOut` is 1 and flag bit 1 is set. When `lvrIn` falls, a new check starts.
- R10: Once the self clock is selected, an external reset leaves it selected and skips the check. Only a power-on or low-voltage reset can start a new check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| porIn | input | 1 | Power-on reset, active high, asynchronous |
| lvrIn | input | 1 | Low-voltage detector level, active high, synchronous |
| extPinIn | input | 1 | External reset pin, active high, asynchronous |
| oscToggleIn | input | 1 | Toggles while the oscillator runs |
| flagClrIn | input | 3 | Write-one-to-clear pulses for the cause flags |
| coreRstOut | output | 1 | Reset to the core, active high |
| clkSelOscOut | output | 1 | 1 selects the oscillator, 0 selects the self clock |
| flagsOut | output | 3 | Sticky reset-cause flags |

## Verification
The bench drives pin pulses at the edge of the width limit, 2 and 3 cycles. A design with an off-by-one in the width counter would either reset on glitches or miss legitimate pulses. The bench measures the delay from each reset source falling to the core being released. A stretch of the wrong length would fall outside the window, and so would a design that ran the check on an external reset while the oscillator was active. The bench stops the oscillator and then applies an external reset, expecting the timeout and a fall back to the self clock. It then applies another external reset and checks that the self clock stays selected; a design that re-ran the check would silently select the oscillator again. Flag checks cover stickiness across later resets and the clear pulse.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

  typedef enum logic [2:0] {
    ST_CHECK   = 3'd0,
    ST_LVR     = 3'd1,
    ST_EXT     = 3'd2,
    ST_STRETCH = 3'd3,
    ST_RUN     = 3'd4
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic runCheck;
    logic runStretch;
    logic selOsc;
    logic selSelf;
    logic setLvr;
    logic setExt;
  } seqStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic extValid;
    logic extHigh;
    logic oscActive;
    logic checkPass;
    logic checkTimeout;
    logic stretchDone;
    logic clkIsOsc;
  } seqStatus_t;

  localparam int FLAG_POR = 0;
  localparam int FLAG_LVR = 1;
  localparam int FLAG_EXT = 2;
  localparam int FLAG_N   = 3;

endpackage

// File: rtl/rcs_sync.sv
module rcs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arstIn,
  input  logic dIn,
  output logic qOut
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or posedge arstIn) begin
    if (arstIn) begin
      chain <= '0;
    end else begin
      chain[0] <= dIn;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign qOut = chain[STAGES-1];

endmodule

// File: rtl/rcs_datapath.sv
module rcs_datapath
  import rcs_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int EXT_MIN_CYCLES = 2,
  parameter int STRETCH_CYCLES = 192,
  parameter int GOOD_EDGES     = 16,
  parameter int GAP_WINDOW     = 8,
  parameter int CQ_TIMEOUT     = 1000
) (
  input  logic              clk,
  input  logic              porIn,
  input  logic              extPinIn,
  input  logic              oscToggleIn,
  input  logic [FLAG_N-1:0] flagClrIn,
  input  seqStrobe_t        strb,
  output seqStatus_t        stat,
  output logic              clkSelOscOut,
  output logic [FLAG_N-1:0] flagsOut
);

  localparam int EXT_W  = $clog2(EXT_MIN_CYCLES + 2);
  localparam int STR_W  = $clog2(STRETCH_CYCLES + 1);
  localparam int EDGE_W = $clog2(GOOD_EDGES + 1);
  localparam int GAP_W  = $clog2(GAP_WINDOW + 1);
  localparam int TO_W   = $clog2(CQ_TIMEOUT + 1);

  localparam logic [EXT_W-1:0]  EXT_LIMIT  = EXT_W'(EXT_MIN_CYCLES + 1);
  localparam logic [STR_W-1:0]  STR_LAST   = STR_W'(STRETCH_CYCLES - 1);
  localparam logic [EDGE_W-1:0] EDGE_GOAL  = EDGE_W'(GOOD_EDGES);
  localparam logic [GAP_W-1:0]  GAP_LIMIT  = GAP_W'(GAP_WINDOW);
  localparam logic [TO_W-1:0]   TO_LIMIT   = TO_W'(CQ_TIMEOUT);

  // synchronizers
  logic pinSync;
  logic oscSync;
  logic oscSyncQ;

  rcs_sync #(.STAGES(SYNC_STAGES)) u_pinSync (
    .clk(clk), .arstIn(porIn), .dIn(extPinIn), .qOut(pinSync)
  );

  rcs_sync #(.STAGES(SYNC_STAGES)) u_oscSync (
    .clk(clk), .arstIn(porIn), .dIn(oscToggleIn), .qOut(oscSync)
  );

  // pin pulse-width counter
  logic [EXT_W-1:0] extCnt;

  always_ff @(posedge clk or posedge porIn) begin
    if (porIn) begin
      extCnt <= '0;
    end else if (!pinSync) begin
      extCnt <= '0;
    end else if (extCnt != EXT_LIMIT) begin
      extCnt <= extCnt + 1'b1;
    end
  end

  // oscillator edge and gap tracking
  logic              oscEdge;
  logic [GAP_W-1:0]  gapCnt;
  logic              gapExpired;

  always_ff @(posedge clk or posedge porIn) begin
    if (porIn) begin
      oscSyncQ <= 1'b0;
    end else begin
      oscSyncQ <= oscSync;
    end
  end

  assign oscEdge    = oscSync ^ oscSyncQ;
  assign gapExpired = (gapCnt == GAP_LIMIT);

  always_ff @(posedge clk or posedge porIn) begin
    if (porIn) begin
      gapCnt <= GAP_LIMIT;
    end else if (oscEdge) begin
      gapCnt <= '0;
    end else if (!gapExpired) begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  // quality check counters
  logic [EDGE_W-1:0] edgeCnt;
  logic [TO_W-1:0]   toCnt;

  always_ff @(posedge clk or posedge porIn) begin
    if (porIn) begin
      edgeCnt <= '0;
    end else if (!strb.runCheck) begin
      edgeCnt <= '0;
    end else if (oscEdge) begin
      if (gapExpired) begin
        edgeCnt <= EDGE_W'(1);
      end else if (edgeCnt != EDGE_GOAL) begin
        edgeCnt <= edgeCnt + 1'b1;
      end
    end else if (gapExpired) begin
      edgeCnt <= '0;
    end
  end

  always_ff @(posedge clk or posedge porIn) begin
    if (porIn) begin
      toCnt <= '0;
    end else if (!strb.runCheck) begin
      toCnt <= '0;
    end else if (toCnt != TO_LIMIT) begin
      toCnt <= toCnt + 1'b1;
    end
  end

  // reset stretch counter
  logic [STR_W-1:0] stCnt;

  always_ff @(posedge clk or posedge porIn) begin
    if (porIn) begin
      stCnt <= '0;
    end else if (!strb.runStretch) begin
      stCnt <= '0;
    end else if (stCnt != STR_LAST) begin
      stCnt <= stCnt + 1'b1;
    end
  end

  // clock select and sticky flags
  logic              clkSelQ;
  logic [FLAG_N-1:0] flagsQ;
  logic [FLAG_N-1:0] flagSet;

  always_ff @(posedge clk or posedge porIn) begin
    if (porIn) begin
      clkSelQ <= 1'b0;
    end else if (strb.selSelf) begin
      clkSelQ <= 1'b0;
    end else if (strb.selOsc) begin
      clkSelQ <= 1'b1;
    end
  end

  always_comb begin
    flagSet           = '0;
    flagSet[FLAG_LVR] = strb.setLvr;
    flagSet[FLAG_EXT] = strb.setExt;
  end

  always_ff @(posedge clk or posedge porIn) begin
    if (porIn) begin
      flagsQ           <= '0;
      flagsQ[FLAG_POR] <= 1'b1;
    end else begin
      flagsQ <= (flagsQ & ~flagClrIn) | flagSet;
    end
  end

  assign stat.extValid     = (extCnt == EXT_LIMIT);
  assign stat.extHigh      = pinSync;
  assign stat.oscActive    = !gapExpired;
  assign stat.checkPass    = (edgeCnt == EDGE_GOAL);
  assign stat.checkTimeout = (toCnt == TO_LIMIT);
  assign stat.stretchDone  = (stCnt == STR_LAST);
  assign stat.clkIsOsc     = clkSelQ;

  assign clkSelOscOut = clkSelQ;
  assign flagsOut     = flagsQ;

  // a flag only drops after a clear pulse on its bit
  p_flag_w1c_r8: assert property (@(posedge clk) disable iff (porIn)
    (~flagsQ & $past(flagsQ) & ~$past(flagClrIn)) == '0);

  // oscillator selected only after a passing check
  p_osc_needs_pass_r4: assert property (@(posedge clk) disable iff (porIn)
    $rose(clkSelQ) |-> ($past(stat.checkPass) && $past(strb.runCheck)));

  // pulse-width counter needs a synchronized high level to grow
  p_ext_width_r1: assert property (@(posedge clk) disable iff (porIn)
    (extCnt != '0) |-> $past(pinSync));

endmodule

// File: rtl/rcs_control.sv
module rcs_control
  import rcs_pkg::*;
(
  input  logic       clk,
  input  logic       porIn,
  input  logic       lvrIn,
  input  seqStatus_t stat,
  output seqStrobe_t strb,
  output logic       coreRstOut
);

  seqState_t stateQ;
  seqState_t stateD;

  always_ff @(posedge clk or posedge porIn) begin
    if (porIn) begin
      stateQ <= ST_CHECK;
    end else begin
      stateQ <= stateD;
    end
  end

  always_comb begin
    stateD          = stateQ;
    strb            = '0;
    strb.runCheck   = (stateQ == ST_CHECK);
    strb.runStretch = (stateQ == ST_STRETCH);
    if (lvrIn) begin
      stateD       = ST_LVR;
      strb.setLvr  = 1'b1;
      strb.selSelf = 1'b1;
    end else if (stat.extValid) begin
      stateD      = ST_EXT;
      strb.setExt = 1'b1;
    end else begin
      unique case (stateQ)
        ST_LVR: stateD = ST_CHECK;
        ST_CHECK: begin
          if (stat.checkPass) begin
            stateD      = ST_STRETCH;
            strb.selOsc = 1'b1;
          end else if (stat.checkTimeout) begin
            stateD       = ST_STRETCH;
            strb.selSelf = 1'b1;
          end
        end
        ST_EXT: begin
          if (!stat.extHigh) begin
            stateD = (stat.oscActive || !stat.clkIsOsc) ? ST_STRETCH : ST_CHECK;
          end
        end
        ST_STRETCH: begin
          if (stat.stretchDone) stateD = ST_RUN;
        end
        ST_RUN: stateD = ST_RUN;
        default: stateD = ST_CHECK;
      endcase
    end
  end

  assign coreRstOut = (stateQ != ST_RUN);

  // the core is only released at the end of a stretch
  p_release_from_stretch_r2: assert property (@(posedge clk) disable iff (porIn)
    $rose(stateQ == ST_RUN) |-> ($past(stateQ) == ST_STRETCH && $past(stat.stretchDone)));

  // low-voltage level holds the core in reset
  p_lvr_hold_r9: assert property (@(posedge clk) disable iff (porIn)
    lvrIn |=> (stateQ == ST_LVR));

  // external reset only entered from a qualified pulse
  p_ext_entry_r1: assert property (@(posedge clk) disable iff (porIn)
    $rose(stateQ == ST_EXT) |-> $past(stat.extValid));

  // with the self clock selected an external reset skips the check
  p_self_sticky_r10: assert property (@(posedge clk) disable iff (porIn)
    (stateQ == ST_EXT && !stat.extHigh && !stat.extValid && !lvrIn && !stat.clkIsOsc)
      |=> (stateQ == ST_STRETCH));

endmodule

// File: rtl/rst_clk_seq.sv
module rst_clk_seq
  import rcs_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int EXT_MIN_CYCLES = 2,
  parameter int STRETCH_CYCLES = 192,
  parameter int GOOD_EDGES     = 16,
  parameter int GAP_WINDOW     = 8,
  parameter int CQ_TIMEOUT     = 1000
) (
  input  logic       clk,
  input  logic       porIn,
  input  logic       lvrIn,
  input  logic       extPinIn,
  input  logic       oscToggleIn,
  input  logic [2:0] flagClrIn,
  output logic       coreRstOut,
  output logic       clkSelOscOut,
  output logic [2:0] flagsOut
);

  seqStrobe_t strb;
  seqStatus_t stat;

  rcs_control u_control (
    .clk        (clk),
    .porIn      (porIn),
    .lvrIn      (lvrIn),
    .stat       (stat),
    .strb       (strb),
    .coreRstOut (coreRstOut)
  );

  rcs_datapath #(
    .SYNC_STAGES    (SYNC_STAGES),
    .EXT_MIN_CYCLES (EXT_MIN_CYCLES),
    .STRETCH_CYCLES (STRETCH_CYCLES),
    .GOOD_EDGES     (GOOD_EDGES),
    .GAP_WINDOW     (GAP_WINDOW),
    .CQ_TIMEOUT     (CQ_TIMEOUT)
  ) u_datapath (
    .clk          (clk),
    .porIn        (porIn),
    .extPinIn     (extPinIn),
    .oscToggleIn  (oscToggleIn),
    .flagClrIn    (flagClrIn),
    .strb         (strb),
    .stat         (stat),
    .clkSelOscOut (clkSelOscOut),
    .flagsOut     (flagsOut)
  );

endmodule

// File: tb/rst_clk_seq_tb.sv
module rst_clk_seq_tb;

  logic       clk = 1'b0;
  logic       porIn = 1'b1;
  logic       lvrIn = 1'b0;
  logic       extPinIn = 1'b0;
  logic       oscToggleIn = 1'b0;
  logic [2:0] flagClrIn = 3'b000;
  logic       coreRstOut;
  logic       clkSelOscOut;
  logic [2:0] flagsOut;

  logic oscOn = 1'b1;
  logic oscDiv = 1'b0;
  int   cyc = 0;
  int   checks = 0;
  int   failures = 0;
  logic done = 1'b0;

  typedef struct {
    string      tag;
    int         mark;
    int         minLat;
    int         maxLat;
    logic       expOsc;
    logic [2:0] expFlags;
  } expItem_t;

  expItem_t expQ[$];

  rst_clk_seq u_dut (
    .clk(clk), .porIn(porIn), .lvrIn(lvrIn), .extPinIn(extPinIn),
    .oscToggleIn(oscToggleIn), .flagClrIn(flagClrIn),
    .coreRstOut(coreRstOut), .clkSelOscOut(clkSelOscOut), .flagsOut(flagsOut)
  );

  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // oscillator model: one toggle every two cycles
  initial begin
    forever begin
      @(negedge clk);
      if (oscOn) begin
        oscDiv = ~oscDiv;
        if (oscDiv) oscToggleIn = ~oscToggleIn;
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expectRelease(input string tag, input int minLat, input int maxLat,
                               input logic expOsc, input logic [2:0] expFlags);
    expItem_t it;
    it.tag = tag; it.mark = cyc; it.minLat = minLat; it.maxLat = maxLat;
    it.expOsc = expOsc; it.expFlags = expFlags;
    expQ.push_back(it);
  endtask

  task automatic waitDrain();
    while (expQ.size() != 0) @(negedge clk);
    waitCyc(4);
  endtask

  task automatic pulseClear(input logic [2:0] v);
    flagClrIn = v;
    @(negedge clk);
    flagClrIn = 3'b000;
    waitCyc(2);
  endtask

  task automatic extPulse(input int n);
    extPinIn = 1'b1;
    waitCyc(n);
    extPinIn = 1'b0;
  endtask

  // monitor: pops an expected item on each release of the core
  initial begin
    logic prevRst;
    expItem_t it;
    prevRst = 1'b1;
    forever begin
      @(negedge clk);
      if (prevRst && !coreRstOut) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R2 unexpected release", 0, 1);
        end else begin
          it = expQ.pop_front();
          chk((cyc - it.mark) >= it.minLat && (cyc - it.mark) <= it.maxLat,
              {it.tag, " release latency"}, cyc - it.mark, it.minLat);
          chk(clkSelOscOut == it.expOsc, {it.tag, " clock select"},
              int'(clkSelOscOut), int'(it.expOsc));
          chk(flagsOut == it.expFlags, {it.tag, " flags"},
              int'(flagsOut), int'(it.expFlags));
        end
      end
      prevRst = coreRstOut;
    end
  end

  // watchdog
  initial begin
    waitCyc(150000);
    chk(1'b0, "watchdog expired", cyc, 150000);
    finishRun();
  end

  initial begin
    waitCyc(5);
    // R3: reset state during power-on reset
    chk(coreRstOut == 1'b1, "R3 core reset during POR", int'(coreRstOut), 1);
    chk(clkSelOscOut == 1'b0, "R3 clock select during POR", int'(clkSelOscOut), 0);
    chk(flagsOut == 3'b001, "R3 flags during POR", int'(flagsOut), 1);

    // R3/R4: release POR with a running oscillator, check passes
    porIn = 1'b0;
    expectRelease("R3 R4 POR check pass", 215, 245, 1'b1, 3'b001);
    waitDrain();

    // R8: clear the POR flag
    pulseClear(3'b001);
    chk(flagsOut == 3'b000, "R8 W1C of POR flag", int'(flagsOut), 0);

    // R1: 2-cycle pulse ignored
    extPulse(2);
    waitCyc(12);
    chk(coreRstOut == 1'b0, "R1 short pulse ignored (reset)", int'(coreRstOut), 0);
    chk(flagsOut == 3'b000, "R1 short pulse ignored (flags)", int'(flagsOut), 0);

    // R1/R2/R6: 3-cycle pulse resets, oscillator active so no check
    extPulse(3);
    expectRelease("R1 R2 R6 ext skip check", 192, 198, 1'b1, 3'b100);
    waitDrain();
    pulseClear(3'b100);
    chk(flagsOut == 3'b000, "R8 W1C of ext flag", int'(flagsOut), 0);

    // R7/R5: oscillator stopped, external reset runs check, times out
    oscOn = 1'b0;
    waitCyc(20);
    extPulse(10);
    expectRelease("R7 R5 ext check timeout", 1185, 1205, 1'b0, 3'b100);
    waitDrain();

    // R10: oscillator back, self clock stays selected on external reset
    oscOn = 1'b1;
    waitCyc(20);
    extPulse(10);
    expectRelease("R10 self clock sticky", 192, 198, 1'b0, 3'b100);
    waitDrain();

    // R9/R4: low-voltage reset starts a new check which passes
    lvrIn = 1'b1;
    waitCyc(10);
    chk(coreRstOut == 1'b1, "R9 core reset during LVR", int'(coreRstOut), 1);
    chk(flagsOut == 3'b110, "R9 LVR flag set, ext flag sticky", int'(flagsOut), 6);
    lvrIn = 1'b0;
    expectRelease("R9 R4 LVR check pass", 215, 245, 1'b1, 3'b110);
    waitDrain();

    // R8: clear all flags
    pulseClear(3'b111);
    chk(flagsOut == 3'b000, "R8 W1C of all flags", int'(flagsOut), 0);
    chk(expQ.size() == 0, "R2 all releases seen", expQ.size(), 0);
    finishRun();
  end

endmodule